// File: doc/BRIEF.md
# Video Memory Repaint Address Sequencer

This block produces the row addresses for the read transfers that refill the serial access port of a dual-ported video memory while the screen is redrawn. It keeps a linear repaint pointer at full resolution. On each read transfer the pointer moves forward by a step of 256, 512 or 1024 bytes, chosen by a 2-bit code. The block presents linear bits 21:10 of the pointer as the next transfer address. At each frame start the pointer is reloaded from a programmable base.

A second counter follows how far the serial port has shifted. Every read transfer clears it. After that it counts the dot-clock enable pulses and holds at its maximum value instead of wrapping. Both outputs come straight from registers and are meant to feed read-only status fields and the memory controller.

Top module: `repaint_addr_seq`

## Requirements
- R1: After reset, `xfer_addr_o` and `shift_cnt_o` are both zero.
- R2: In the cycle after `xfer_i` is high, the linear pointer has grown by the step that `step_sel_i` selects: 2'b00 selects 256, 2'b01 selects 512 and 2'b10 selects 1024.
- R3: The reserved code 2'b11 on `step_sel_i` gives the same step as 2'b10, which is 1024.
- R4: `xfer_addr_o` reports linear bits 21:10 of the pointer. Bits below bit 10 are kept internally, so four steps of 256 or two steps of 512 advance `xfer_addr_o` by exactly 1.
- R5: In the cycle after `frame_start_i` is high, the pointer equals `base_i` shifted left by 10 bits. This load wins over a transfer in the same cycle.
- R6: In the cycle after `xfer_i` is high, `shift_cnt_o` is zero, even when `dot_en_i` was high in that cycle.
- R7: When `xfer_i` is low, each cycle with `dot_en_i` high raises `shift_cnt_o` by one.
- R8: `shift_cnt_o` holds at 4095 and does not wrap.
- R9: When `xfer_i` and `frame_start_i` are both low, the pointer holds its value. The pointer wraps modulo 2^22, so a 1024 step from `xfer_addr_o` = 0xFFF gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame start; reloads the pointer from the base |
| xfer_i | input | 1 | Read-transfer strobe |
| dot_en_i | input | 1 | Dot-clock enable for the shift counter |
| step_sel_i | input | 2 | Step code (00=256, 01=512, 10/11=1024) |
| base_i | input | 12 | Frame base address, in units of linear bits 21:10 |
| xfer_addr_o | output | 12 | Next transfer address, linear bits 21:10 |
| shift_cnt_o | output | 12 | Serial shift counter |

## Verification
The bench runs sub-1024 steps that cross a 1024 boundary only after several transfers. A design that drops the low pointer bits would freeze or jump the reported address.

Three cases test priority and encoding:
- A frame start and a transfer in the same cycle check load priority. The wrong priority would report the base plus one step.
- The reserved step code is checked. A design that decodes it as zero or as 256 would stall.
- The shift counter gets a transfer together with a dot pulse. Here it must clear and not count.

The counter is then driven past 4095 to show it saturates and does not roll over to zero. A step from the top of the address space confirms that the pointer wraps within 22 bits.

// File: rtl/repaint_pkg.sv
package repaint_pkg;
  typedef enum logic [1:0] {
    STEP_256  = 2'b00,
    STEP_512  = 2'b01,
    STEP_1024 = 2'b10,
    STEP_RSVD = 2'b11
  } step_sel_e;
endpackage

// File: rtl/repaint_step_dec.sv
module repaint_step_dec
  import repaint_pkg::*;
#(
  parameter int LIN_W = 22
) (
  input  step_sel_e        sel_i,
  output logic [LIN_W-1:0] step_o
);
  always_comb begin
    case (sel_i)
      STEP_256: step_o = LIN_W'(256);
      STEP_512: step_o = LIN_W'(512);
      default:  step_o = LIN_W'(1024); // reserved code aliases 1024
    endcase
  end
endmodule

// File: rtl/repaint_addr_acc.sv
module repaint_addr_acc #(
  parameter int LIN_W   = 22,
  parameter int OUT_LSB = 10,
  localparam int OUT_W  = LIN_W - OUT_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             xfer_i,
  input  logic [OUT_W-1:0] base_i,
  input  logic [LIN_W-1:0] step_i,
  output logic [LIN_W-1:0] addr_o
);
  logic [LIN_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            addr_q <= '0;
    else if (frame_start_i) addr_q <= {base_i, {OUT_LSB{1'b0}}};
    else if (xfer_i)        addr_q <= addr_q + step_i;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/repaint_shift_cnt.sv
module repaint_shift_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/repaint_addr_seq.sv
module repaint_addr_seq
  import repaint_pkg::*;
#(
  parameter int LIN_W   = 22,
  parameter int OUT_LSB = 10,
  parameter int CNT_W   = 12,
  localparam int OUT_W  = LIN_W - OUT_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             xfer_i,
  input  logic             dot_en_i,
  input  logic [1:0]       step_sel_i,
  input  logic [OUT_W-1:0] base_i,
  output logic [OUT_W-1:0] xfer_addr_o,
  output logic [CNT_W-1:0] shift_cnt_o
);
  logic [LIN_W-1:0] step;
  logic [LIN_W-1:0] lin_addr;

  repaint_step_dec #(.LIN_W(LIN_W)) u_dec (
    .sel_i  (step_sel_e'(step_sel_i)),
    .step_o (step)
  );

  repaint_addr_acc #(.LIN_W(LIN_W), .OUT_LSB(OUT_LSB)) u_acc (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .xfer_i        (xfer_i),
    .base_i        (base_i),
    .step_i        (step),
    .addr_o        (lin_addr)
  );

  repaint_shift_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (xfer_i),
    .inc_i  (dot_en_i),
    .cnt_o  (shift_cnt_o)
  );

  assign xfer_addr_o = lin_addr[LIN_W-1:OUT_LSB];
endmodule

// File: rtl/repaint_addr_seq_chk.sv
module repaint_addr_seq_chk #(
  parameter int LIN_W   = 22,
  parameter int OUT_LSB = 10,
  parameter int CNT_W   = 12,
  localparam int OUT_W  = LIN_W - OUT_LSB
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_start_i,
  input logic             xfer_i,
  input logic             dot_en_i,
  input logic [1:0]       step_sel_i,
  input logic [OUT_W-1:0] base_i,
  input logic [LIN_W-1:0] lin_addr,
  input logic [CNT_W-1:0] shift_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [LIN_W-1:0] chk_step(logic [1:0] s);
    case (s)
      2'b00:   return LIN_W'(256);
      2'b01:   return LIN_W'(512);
      default: return LIN_W'(1024);
    endcase
  endfunction

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !frame_start_i) |=>
      lin_addr == LIN_W'($past(lin_addr) + chk_step($past(step_sel_i))));

  assert_base_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> lin_addr == {$past(base_i), {OUT_LSB{1'b0}}});

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_i && !frame_start_i) |=> $stable(lin_addr));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> shift_cnt_o == '0);

  assert_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_i && dot_en_i && shift_cnt_o != CNT_MAX) |=>
      shift_cnt_o == $past(shift_cnt_o) + 1'b1);

  assert_saturate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_i && shift_cnt_o == CNT_MAX) |=> shift_cnt_o == CNT_MAX);
endmodule

bind repaint_addr_seq repaint_addr_seq_chk #(
  .LIN_W(LIN_W), .OUT_LSB(OUT_LSB), .CNT_W(CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .xfer_i        (xfer_i),
  .dot_en_i      (dot_en_i),
  .step_sel_i    (step_sel_i),
  .base_i        (base_i),
  .lin_addr      (lin_addr),
  .shift_cnt_o   (shift_cnt_o)
);

// File: tb/repaint_addr_seq_bench.sv
module repaint_addr_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_start_i = 1'b0;
  logic        xfer_i = 1'b0;
  logic        dot_en_i = 1'b0;
  logic [1:0]  step_sel_i = 2'b00;
  logic [11:0] base_i = 12'h000;
  logic [11:0] xfer_addr_o;
  logic [11:0] shift_cnt_o;

  int checks = 0;
  int failures = 0;

  logic [23:0] exp_q[$];
  int          req_q[$];
  logic [21:0] m_lin = '0;
  logic [11:0] m_sh  = '0;

  always #5 clk_i = ~clk_i;

  repaint_addr_seq u_repaint_addr_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .xfer_i(xfer_i), .dot_en_i(dot_en_i), .step_sel_i(step_sel_i),
    .base_i(base_i), .xfer_addr_o(xfer_addr_o), .shift_cnt_o(shift_cnt_o)
  );

  function automatic logic [21:0] model_step(logic [1:0] s);
    case (s)
      2'b00:   return 22'd256;
      2'b01:   return 22'd512;
      default: return 22'd1024;
    endcase
  endfunction

  // Driver: apply one cycle of stimulus, push expected post-edge outputs.
  task automatic drive(bit fs, bit xf, bit de, logic [1:0] sel,
                       logic [11:0] b, int req);
    @(negedge clk_i);
    frame_start_i = fs; xfer_i = xf; dot_en_i = de;
    step_sel_i = sel; base_i = b;
    if (fs)      m_lin = {b, 10'b0};
    else if (xf) m_lin = m_lin + model_step(sel);
    if (xf)                      m_sh = '0;
    else if (de && m_sh != 12'hFFF) m_sh = m_sh + 1'b1;
    exp_q.push_back({m_lin[21:10], m_sh});
    req_q.push_back(req);
  endtask

  // Monitor: compare shortly after each rising edge.
  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [23:0] e;
      int r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if ({xfer_addr_o, shift_cnt_o} !== e) begin
        failures++;
        $display("FAIL R%0d addr=%h shift=%0d expected addr=%h shift=%0d",
                 r, xfer_addr_o, shift_cnt_o, e[23:12], e[11:0]);
      end
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++; // R1 reset state
    if (xfer_addr_o !== 12'h000 || shift_cnt_o !== 12'h000) begin
      failures++;
      $display("FAIL R1 addr=%h shift=%0d expected addr=000 shift=0",
               xfer_addr_o, shift_cnt_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    drive(0, 1, 0, 2'b10, 0, 2);            // R2 step 1024 -> 1
    drive(0, 1, 0, 2'b01, 0, 4);            // R4 512 -> lin 1536, addr 1
    drive(0, 1, 0, 2'b01, 0, 4);            // R4 -> addr 2
    for (int i = 0; i < 4; i++)
      drive(0, 1, 0, 2'b00, 0, 4);          // R4 four 256 steps -> addr 3
    drive(0, 1, 0, 2'b11, 0, 3);            // R3 reserved code -> addr 4
    for (int i = 0; i < 5; i++)
      drive(0, 0, 1, 2'b00, 0, 7);          // R7 counting
    drive(0, 1, 1, 2'b00, 0, 6);            // R6 clear beats dot pulse
    for (int i = 0; i < 3; i++)
      drive(0, 0, 0, 2'b10, 12'h555, 9);    // R9 hold while idle
    drive(1, 1, 0, 2'b10, 12'h123, 5);      // R5 frame wins over transfer
    drive(0, 1, 0, 2'b00, 12'h123, 2);      // R2 256 step from base
    drive(1, 0, 0, 2'b00, 12'hFFF, 5);      // R5 base at top
    drive(0, 1, 0, 2'b10, 12'hFFF, 9);      // R9 wrap to 0
    for (int i = 0; i < 4100; i++)
      drive(0, 0, 1, 2'b00, 0, 8);          // R8 saturation at 4095
    drive(0, 1, 0, 2'b00, 0, 6);            // R6 clear from saturation
    drive(0, 0, 0, 2'b00, 0, 9);
    repeat (3) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule